// File: doc/BRIEF.md
# Charge and Discharge Time Counter with Rollover Slowdown

This block measures how long a battery pack has spent discharging and how long it has spent charging. It keeps one 16-bit time counter for each direction. A base tick arrives at 4096 ticks per hour, so one tick lasts about 0.879 s. While the sense signal is above the wake threshold, the counter for the current direction advances on each qualified tick. If a counter wraps past its all-ones value, it latches a slow-rate flag. From then on it advances only once per 256 qualified ticks, which is 16 counts per hour, so its reach becomes much longer. The host can also set or clear either slow-rate flag directly.

A small power-mode controller gates all counting. It counts base ticks while the sense signal is below the threshold and the host line is low. After a configurable number of such ticks (12 by default, a little over 10 s) it puts the block to sleep. The block stays asleep until the host line returns high. A registered active-low wake output is driven low whenever both the sense signal is active and the host line is high.

Top module: `dirtime_counter`

## Requirements
- R1: After reset both counters read 0, both slow-rate flags read 0, the block is awake (`asleep_o` = 0), and `wake_o` = 1.
- R2: With `sense_dir` = 1 (discharge), each clock with `tick`, `run_en` and `sense_active` all high and the block awake increments `dis_count` by one in the following cycle, while `chg_count` holds.
- R3: With `sense_dir` = 0 (charge), each such qualified tick increments `chg_count` by one, while `dis_count` holds.
- R4: No counter changes on a clock where `tick` is low, `run_en` is low, or `sense_active` is low.
- R5: A counter at 16'hFFFF that receives an increment wraps to 0 and sets its slow-rate flag. Flag bit 0 belongs to the discharge counter and bit 1 to the charge counter.
- R6: While a slow-rate flag is set, its counter advances once per 256 qualified ticks. The first advance comes on the 256th qualified tick after the flag was set.
- R7: A clock with `slow_wr_en` high loads `slow_bits` from `slow_wr_data`, using the same bit positions as R5. Setting a bit forces that counter to the slow rate under R6. Clearing a bit restores one count per qualified tick. An overflow on the same clock still sets its flag.
- R8: `wake_o` is 0 in the cycle after a clock on which `sense_active` and `host_line` are both high, and 1 in the cycle after any other clock.
- R9: When `sense_active` and `host_line` are both low, the block enters sleep (`asleep_o` = 1) on the IDLE_TICKS-th consecutive idle base tick, and not before.
- R10: Any clock with `host_line` high or `sense_active` high restarts the idle tick count from zero.
- R11: While asleep, no counter advances, even with `sense_active` high. Sleep ends one clock after `host_line` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle base tick, 4096 per hour |
| run_en | input | 1 | Counting enable |
| sense_active | input | 1 | Sense signal is above the wake threshold |
| sense_dir | input | 1 | Current direction: 1 = discharge, 0 = charge |
| host_line | input | 1 | Level of the host line |
| slow_wr_en | input | 1 | Host write strobe for the slow-rate flags |
| slow_wr_data | input | 2 | Value to write to the slow-rate flags |
| dis_count | output | 16 | Discharge time count |
| chg_count | output | 16 | Charge time count |
| slow_bits | output | 2 | Slow-rate flags: bit 0 = discharge, bit 1 = charge |
| asleep_o | output | 1 | Block is in sleep |
| wake_o | output | 1 | Active-low wake output |

## Verification
The assertions are checked on every clock. They cover these properties:
- A counter moves only on a qualified step, and the two counters never move together.
- In slow mode a counter steps only from the top of its prescaler.
- A flag that rises without a host write comes from a wrap to zero.
- Sleep is entered only from an idle tick and left only after the host line was high.
- The wake output is high whenever the block is asleep.

Other behaviours need the bench's directed scenarios, because they depend on exact counts over long runs:
- the 65536-tick wrap;
- the full 256-tick gap before the first slow count;
- the restoration of the normal rate after a host clear;
- the exact tick on which sleep begins after a restart of the idle count.

// File: rtl/dirtime_pkg.sv
package dirtime_pkg;
  localparam int NUM_LANES = 2;
  localparam int LANE_DIS  = 0;
  localparam int LANE_CHG  = 1;

  typedef enum logic {
    PM_AWAKE = 1'b0,
    PM_SLEEP = 1'b1
  } pm_state_t;
endpackage

// File: rtl/dirtime_lane.sv
module dirtime_lane #(
  parameter int CNT_W    = 16,
  parameter int SLOW_DIV = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             wr_en,
  input  logic             wr_val,
  output logic [CNT_W-1:0] cnt,
  output logic             slow
);
  localparam int PRE_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(SLOW_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic             slow_q;
  logic             pre_top;
  logic             inc;
  logic             wrap;
  logic             slow_nxt;

  assign pre_top  = (pre_q == PRE_TOP);
  assign inc      = step && (!slow_q || pre_top);
  assign wrap     = inc && (cnt_q == {CNT_W{1'b1}});
  // a wrap sets the flag even when the host clears it on the same clock
  assign slow_nxt = (wr_en ? wr_val : slow_q) | wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pre_q  <= '0;
      slow_q <= 1'b0;
    end else begin
      if (inc) cnt_q <= cnt_q + 1'b1;
      slow_q <= slow_nxt;
      // restart the divider on every rate change
      if (slow_nxt != slow_q)  pre_q <= '0;
      else if (step && slow_q) pre_q <= pre_top ? '0 : pre_q + 1'b1;
    end
  end

  assign cnt  = cnt_q;
  assign slow = slow_q;

  // R2
  cnt_needs_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != $past(cnt_q)) |-> $past(step));

  // R6
  slow_from_top_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(slow_q) && (cnt_q != $past(cnt_q))) |-> ($past(pre_q) == PRE_TOP));

  // R5
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(slow_q) && !$past(wr_en)) |-> (cnt_q == '0));
endmodule

// File: rtl/dirtime_power.sv
module dirtime_power #(
  parameter int IDLE_TICKS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sense_active,
  input  logic host_line,
  output logic asleep,
  output logic wake_o
);
  import dirtime_pkg::*;

  localparam int IDLE_W = $clog2(IDLE_TICKS + 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_TICKS - 1);

  pm_state_t       state_q;
  logic [IDLE_W-1:0] idle_q;
  logic            wake_q;
  logic            idle_cond;

  assign idle_cond = !sense_active && !host_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PM_AWAKE;
      idle_q  <= '0;
      wake_q  <= 1'b1;
    end else begin
      wake_q <= !(sense_active && host_line);
      if (!idle_cond) begin
        idle_q <= '0;
      end else if (state_q == PM_AWAKE && tick) begin
        if (idle_q == IDLE_LAST) begin
          state_q <= PM_SLEEP;
          idle_q  <= '0;
        end else begin
          idle_q <= idle_q + 1'b1;
        end
      end
      if (host_line) state_q <= PM_AWAKE;
    end
  end

  assign asleep = (state_q == PM_SLEEP);
  assign wake_o = wake_q;

  // R9
  sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(asleep) |-> $past(tick && !sense_active && !host_line));

  // R11
  sleep_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(asleep) |-> $past(host_line));

  // R8
  wake_high_asleep_chk: assert property (@(posedge clk) disable iff (rst)
    asleep |-> wake_o);
endmodule

// File: rtl/dirtime_counter.sv
module dirtime_counter #(
  parameter int CNT_W      = 16,
  parameter int SLOW_DIV   = 256,
  parameter int IDLE_TICKS = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run_en,
  input  logic             sense_active,
  input  logic             sense_dir,
  input  logic             host_line,
  input  logic             slow_wr_en,
  input  logic [1:0]       slow_wr_data,
  output logic [CNT_W-1:0] dis_count,
  output logic [CNT_W-1:0] chg_count,
  output logic [1:0]       slow_bits,
  output logic             asleep_o,
  output logic             wake_o
);
  import dirtime_pkg::*;

  logic                 asleep;
  logic                 gate;
  logic [NUM_LANES-1:0] step;
  logic [CNT_W-1:0]     lane_cnt [NUM_LANES];
  logic [NUM_LANES-1:0] lane_slow;

  dirtime_power #(.IDLE_TICKS(IDLE_TICKS)) u_power (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .sense_active (sense_active),
    .host_line    (host_line),
    .asleep       (asleep),
    .wake_o       (wake_o)
  );

  assign gate = tick && run_en && sense_active && !asleep;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam logic LANE_DIR = (i == LANE_DIS);
    assign step[i] = gate && (sense_dir == LANE_DIR);
    dirtime_lane #(.CNT_W(CNT_W), .SLOW_DIV(SLOW_DIV)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .step   (step[i]),
      .wr_en  (slow_wr_en),
      .wr_val (slow_wr_data[i]),
      .cnt    (lane_cnt[i]),
      .slow   (lane_slow[i])
    );
  end

  assign dis_count = lane_cnt[LANE_DIS];
  assign chg_count = lane_cnt[LANE_CHG];
  assign slow_bits = lane_slow;
  assign asleep_o  = asleep;

  // R3
  one_direction_chk: assert property (@(posedge clk) disable iff (rst)
    !((dis_count != $past(dis_count)) && (chg_count != $past(chg_count))));

  // R11
  frozen_asleep_chk: assert property (@(posedge clk) disable iff (rst)
    $past(asleep) |-> ((dis_count == $past(dis_count)) && (chg_count == $past(chg_count))));
endmodule

// File: tb/dirtime_counter_tb.sv
module dirtime_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE = 12;

  logic        clk = 1'b0;
  logic        rst;
  logic        tick, run_en, sense_active, sense_dir, host_line, slow_wr_en;
  logic [1:0]  slow_wr_data;
  logic [15:0] dis_count, chg_count;
  logic [1:0]  slow_bits;
  logic        asleep_o, wake_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dirtime_counter #(.IDLE_TICKS(IDLE)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .run_en(run_en),
    .sense_active(sense_active), .sense_dir(sense_dir), .host_line(host_line),
    .slow_wr_en(slow_wr_en), .slow_wr_data(slow_wr_data),
    .dis_count(dis_count), .chg_count(chg_count), .slow_bits(slow_bits),
    .asleep_o(asleep_o), .wake_o(wake_o)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; tick = 0; run_en = 1; sense_active = 1; sense_dir = 1;
    host_line = 1; slow_wr_en = 0; slow_wr_data = 2'b00;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
    end
    @(negedge clk); tick = 0;
  endtask

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_slow(logic [1:0] v);
    @(negedge clk); slow_wr_en = 1; slow_wr_data = v;
    @(negedge clk); slow_wr_en = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 dis", dis_count, 0);
    chk("R1 chg", chg_count, 0);
    chk("R1 slow", slow_bits, 0);
    chk("R1 asleep", asleep_o, 0);
    @(negedge clk); rst = 1; sense_active = 0; @(negedge clk); rst = 0;
    chk("R1 wake", wake_o, 1);
  endtask

  task automatic t_directions();
    do_reset();
    sense_dir = 1; ticks(5);
    chk("R2 dis", dis_count, 5);
    chk("R2 chg hold", chg_count, 0);
    sense_dir = 0; ticks(7);
    chk("R3 chg", chg_count, 7);
    chk("R3 dis hold", dis_count, 5);
  endtask

  task automatic t_gating();
    do_reset();
    sense_dir = 1; idle_cycles(6);
    chk("R4 no tick", dis_count, 0);
    run_en = 0; ticks(4);
    chk("R4 run_en low", dis_count, 0);
    run_en = 1; sense_active = 0; ticks(4);
    chk("R4 sense low", dis_count, 0);
    sense_active = 1; ticks(1);
    chk("R4 resumes", dis_count, 1);
  endtask

  task automatic t_wrap_and_slow();
    do_reset();
    sense_dir = 1; ticks(65535);
    chk("R5 at max", dis_count, 16'hFFFF);
    chk("R5 flag clear", slow_bits, 0);
    ticks(1);
    chk("R5 wrapped", dis_count, 0);
    chk("R5 flag set", slow_bits, 2'b01);
    ticks(255);
    chk("R6 no step yet", dis_count, 0);
    ticks(1);
    chk("R6 first slow step", dis_count, 1);
    ticks(256);
    chk("R6 second slow step", dis_count, 2);
    write_slow(2'b00);
    chk("R7 cleared", slow_bits, 0);
    ticks(3);
    chk("R7 normal rate back", dis_count, 5);
  endtask

  task automatic t_host_slow();
    do_reset();
    sense_dir = 0; ticks(2);
    write_slow(2'b10);
    chk("R7 set chg flag", slow_bits, 2'b10);
    ticks(255);
    chk("R7 forced slow", chg_count, 2);
    ticks(1);
    chk("R7 slow step", chg_count, 3);
    chk("R7 dis untouched", dis_count, 0);
  endtask

  task automatic t_sleep();
    do_reset();
    sense_active = 1; host_line = 1; @(negedge clk);
    chk("R8 wake low", wake_o, 0);
    host_line = 0; @(negedge clk);
    chk("R8 wake high", wake_o, 1);
    sense_active = 0; ticks(IDLE - 1);
    chk("R9 not yet asleep", asleep_o, 0);
    ticks(1);
    chk("R9 asleep", asleep_o, 1);
    chk("R8 wake asleep", wake_o, 1);
    sense_active = 1; sense_dir = 1; ticks(5);
    chk("R11 frozen", dis_count, 0);
    chk("R11 still asleep", asleep_o, 1);
    host_line = 1; @(negedge clk);
    chk("R11 woke", asleep_o, 0);
    chk("R8 full op", wake_o, 0);
    ticks(2);
    chk("R11 counts again", dis_count, 2);
  endtask

  task automatic t_idle_restart();
    do_reset();
    sense_active = 0; host_line = 0; @(negedge clk);
    ticks(IDLE - 1);
    host_line = 1; @(negedge clk); host_line = 0;
    ticks(IDLE - 1);
    chk("R10 host restart", asleep_o, 0);
    sense_active = 1; @(negedge clk); sense_active = 0;
    ticks(IDLE - 1);
    chk("R10 sense restart", asleep_o, 0);
    ticks(1);
    chk("R10 sleeps after full run", asleep_o, 1);
  endtask

  initial begin
    t_reset();
    t_directions();
    t_gating();
    t_wrap_and_slow();
    t_host_slow();
    t_sleep();
    t_idle_restart();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule